// File: doc/BRIEF.md
# Partitioned Masked CAM Array

This block is a 16-entry content-addressable memory. Each entry carries a 64-bit word and a 2-bit validity code. A partition code divides every word into a searchable field and an associated-data field in 16-bit steps, and the associated-data field can sit at either end of the word. A compare checks the comparand against all valid entries at once. It ignores the associated-data bits and every bit whose compare mask bit is 1. It then reports a hit flag and the lowest-numbered matching entry. The block also keeps the lowest-numbered empty entry available as a free pointer, and raises a full flag when there is none.

Reads, writes and validity updates pick their target from one of four pointer sources: the explicit address input, an internal address register, the free pointer or the match pointer. A write can be masked so that only the bits whose mask bit is 0 change. A small result machine holds the outcome of the last compare. Its states are RES_IDLE (no compare since reset), RES_HIT and RES_MISS. A compare with a hit moves it to RES_HIT. A compare without one moves it to RES_MISS. While in RES_HIT, a validity update that moves the matched entry away from valid sends it to RES_MISS. Reset returns it to RES_IDLE.

Top module: `cam_part_array`

## Requirements
- R1: After reset every entry is empty (validity 01). match_o is 0, match_addr_o is 0, free_addr_o is 0, full_o is 0 and rd_data_o is 0.
- R2: Opcode op_i values are 0 NOP, 1 compare, 2 write, 3 read, 4 set validity and 5 load address register. A write stores wdata_i in the target entry and marks it valid (00). A read loads the target word into rd_data_o on that clock edge, and rd_data_o changes on no other opcode.
- R3: When wmask_en_i is 1, a write changes only the target bits whose mask_i bit is 0 and keeps the bits whose mask_i bit is 1. When wmask_en_i is 0, the whole word is written.
- R4: src_i selects the target: 0 selects addr_i, 1 the address register (loaded from addr_i by opcode 5), 2 the free pointer, and 3 the match pointer.
- R5: part_i[1:0] gives the number of 16-bit associated-data segments (0 to 3). part_i[2]=0 places them at the least-significant end and part_i[2]=1 at the most-significant end. Those bits never affect a compare.
- R6: Within the searchable field, a comparand bit takes part in the compare when its mask_i bit is 0 and is excluded when it is 1.
- R7: Opcode 4 sets the target's validity to wdata_i[1:0]. The codes are 00 valid, 01 empty, 10 skip and 11 random-access. Only entries coded 00 can match.
- R8: On a hit, match_o is 1 and match_addr_o is the lowest-numbered matching entry. On no hit, match_o is 0 and match_addr_o is 0.
- R9: free_addr_o is the lowest-numbered empty entry and follows a write or validity change one clock later. When no entry is empty, full_o is 1 and free_addr_o is 0.
- R10: An operation that selects the free pointer while full_o is 1, or the match pointer while match_o is 0, changes nothing.
- R11: Match results update on the clock edge of a compare and hold otherwise. The one exception is a validity update that moves the matched entry away from valid: it clears match_o and match_addr_o on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Opcode |
| src_i | input | 2 | Target pointer select |
| addr_i | input | 4 | Explicit address, also address register load value |
| wdata_i | input | 64 | Write data; bits 1:0 carry the validity code for opcode 4 |
| mask_i | input | 64 | Compare mask and write mask (1 = excluded / kept) |
| wmask_en_i | input | 1 | Apply mask_i to writes |
| cmp_i | input | 64 | Comparand |
| part_i | input | 3 | Partition code |
| rd_data_o | output | 64 | Registered read data |
| match_o | output | 1 | Last compare found a valid match |
| match_addr_o | output | 4 | Highest-priority match entry |
| free_addr_o | output | 4 | Lowest-numbered empty entry |
| full_o | output | 1 | No empty entry |

## Verification
A corrupted validity code shows at free_addr_o or full_o one clock after the write or validity change that set it, and at the next compare through a wrong hit. A wrong stored word stays hidden until a read of that entry or a compare that touches its searchable bits, so the bench reads back every word it depends on. A result machine stuck in the wrong state shows directly on match_o. A stale match pointer shows up only when a read or write sourced from it lands on the wrong entry, which the bench observes by reading back or by watching the free pointer.

// File: rtl/cam_pkg.sv
package cam_pkg;

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_CMP   = 3'd1,
        OP_WRITE = 3'd2,
        OP_READ  = 3'd3,
        OP_SETV  = 3'd4,
        OP_LDAR  = 3'd5
    } cam_op_e;

    typedef enum logic [1:0] {
        SRC_ADDR  = 2'd0,
        SRC_AREG  = 2'd1,
        SRC_FREE  = 2'd2,
        SRC_MATCH = 2'd3
    } cam_src_e;

    typedef enum logic [1:0] {
        RES_IDLE = 2'd0,
        RES_HIT  = 2'd1,
        RES_MISS = 2'd2
    } cam_res_e;

    localparam logic [1:0] VLD_VALID = 2'b00;
    localparam logic [1:0] VLD_EMPTY = 2'b01;
    localparam logic [1:0] VLD_SKIP  = 2'b10;
    localparam logic [1:0] VLD_RAND  = 2'b11;

endpackage

// File: rtl/cam_field_mask.sv
// Turns a partition code into a per-bit searchable-field mask (1 = searchable).
module cam_field_mask #(
    parameter int W   = 64,
    parameter int SEG = 16,
    localparam int SEGS = W / SEG,
    localparam int CW   = $clog2(SEGS)
) (
    input  logic [CW:0]  part_i,
    output logic [W-1:0] care_o
);
    logic [CW-1:0] ram_segs;
    logic          ram_high;
    logic [SEGS-1:0] is_ram;

    assign ram_segs = part_i[CW-1:0];
    assign ram_high = part_i[CW];

    for (genvar s = 0; s < SEGS; s++) begin : g_seg
        assign is_ram[s] = ram_high ? (int'(ram_segs) > (SEGS - 1 - s))
                                    : (int'(ram_segs) > s);
        assign care_o[s*SEG +: SEG] = is_ram[s] ? '0 : '1;
    end
endmodule

// File: rtl/cam_prio_enc.sv
// Lowest-index-wins priority encoder; index is 0 when nothing is requested.
module cam_prio_enc #(
    parameter int N = 16,
    localparam int AW = $clog2(N)
) (
    input  logic [N-1:0]  req_i,
    output logic          any_o,
    output logic [AW-1:0] idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = AW'(i);
        end
    end
    assign any_o = |req_i;
endmodule

// File: rtl/cam_store.sv
// Entry words, validity codes and the parallel compare.
module cam_store
    import cam_pkg::*;
#(
    parameter int N = 16,
    parameter int W = 64,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_idx_i,
    input  logic [W-1:0]  wr_word_i,
    input  logic          v_en_i,
    input  logic [AW-1:0] v_idx_i,
    input  logic [1:0]    v_val_i,
    input  logic [AW-1:0] rd_idx_i,
    output logic [W-1:0]  rd_word_o,
    input  logic [W-1:0]  cmp_i,
    input  logic [W-1:0]  care_i,
    output logic [N-1:0]  hit_o,
    output logic [N-1:0]  empty_o
);
    logic [W-1:0] words [N];
    logic [1:0]   vcode [N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                words[i] <= '0;
                vcode[i] <= VLD_EMPTY;
            end
        end else begin
            if (wr_en_i) begin
                words[wr_idx_i] <= wr_word_i;
                vcode[wr_idx_i] <= VLD_VALID;
            end
            if (v_en_i) begin
                vcode[v_idx_i] <= v_val_i;
            end
        end
    end

    assign rd_word_o = words[rd_idx_i];

    for (genvar e = 0; e < N; e++) begin : g_ent
        assign hit_o[e]   = (vcode[e] == VLD_VALID) &&
                            (((words[e] ^ cmp_i) & care_i) == '0);
        assign empty_o[e] = (vcode[e] == VLD_EMPTY);
    end
endmodule

// File: rtl/cam_part_array.sv
module cam_part_array
    import cam_pkg::*;
#(
    parameter int N_ENT = 16,
    parameter int W     = 64,
    parameter int SEG   = 16,
    localparam int AW   = $clog2(N_ENT),
    localparam int SEGS = W / SEG,
    localparam int PW   = $clog2(SEGS) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    op_i,
    input  logic [1:0]    src_i,
    input  logic [AW-1:0] addr_i,
    input  logic [W-1:0]  wdata_i,
    input  logic [W-1:0]  mask_i,
    input  logic          wmask_en_i,
    input  logic [W-1:0]  cmp_i,
    input  logic [PW-1:0] part_i,
    output logic [W-1:0]  rd_data_o,
    output logic          match_o,
    output logic [AW-1:0] match_addr_o,
    output logic [AW-1:0] free_addr_o,
    output logic          full_o
);
    cam_op_e       op;
    cam_res_e      state_q, state_d;
    logic [AW-1:0] maddr_q, maddr_d;
    logic [AW-1:0] areg_q;
    logic [W-1:0]  rd_q;

    logic [W-1:0]  field_care, care;
    logic [N_ENT-1:0] hit_vec, empty_vec;
    logic          hit_any, free_any;
    logic [AW-1:0] hit_idx, free_idx;
    logic [AW-1:0] tgt_idx;
    logic          tgt_ok;
    logic [W-1:0]  old_word, new_word;
    logic          do_write, do_setv, do_read, drop_match;

    assign op = cam_op_e'(op_i);

    cam_field_mask #(.W(W), .SEG(SEG)) u_field (
        .part_i (part_i),
        .care_o (field_care)
    );

    assign care = field_care & ~mask_i;

    cam_store #(.N(N_ENT), .W(W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (do_write),
        .wr_idx_i  (tgt_idx),
        .wr_word_i (new_word),
        .v_en_i    (do_setv),
        .v_idx_i   (tgt_idx),
        .v_val_i   (wdata_i[1:0]),
        .rd_idx_i  (tgt_idx),
        .rd_word_o (old_word),
        .cmp_i     (cmp_i),
        .care_i    (care),
        .hit_o     (hit_vec),
        .empty_o   (empty_vec)
    );

    cam_prio_enc #(.N(N_ENT)) u_hit_enc (
        .req_i (hit_vec),
        .any_o (hit_any),
        .idx_o (hit_idx)
    );

    cam_prio_enc #(.N(N_ENT)) u_free_enc (
        .req_i (empty_vec),
        .any_o (free_any),
        .idx_o (free_idx)
    );

    // Target pointer selection and its validity
    always_comb begin
        tgt_idx = addr_i;
        tgt_ok  = 1'b1;
        unique case (cam_src_e'(src_i))
            SRC_ADDR:  begin tgt_idx = addr_i;   tgt_ok = 1'b1;               end
            SRC_AREG:  begin tgt_idx = areg_q;   tgt_ok = 1'b1;               end
            SRC_FREE:  begin tgt_idx = free_idx; tgt_ok = free_any;           end
            SRC_MATCH: begin tgt_idx = maddr_q;  tgt_ok = (state_q == RES_HIT); end
        endcase
    end

    assign do_write = (op == OP_WRITE) && tgt_ok;
    assign do_setv  = (op == OP_SETV)  && tgt_ok;
    assign do_read  = (op == OP_READ)  && tgt_ok;
    assign new_word = wmask_en_i ? ((old_word & mask_i) | (wdata_i & ~mask_i))
                                 : wdata_i;
    assign drop_match = do_setv && (tgt_idx == maddr_q) &&
                        (wdata_i[1:0] != VLD_VALID);

    // Result state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RES_IDLE;
            maddr_q <= '0;
        end else begin
            state_q <= state_d;
            maddr_q <= maddr_d;
        end
    end

    // Result next-state logic
    always_comb begin
        state_d = state_q;
        maddr_d = maddr_q;
        unique case (state_q)
            RES_IDLE, RES_MISS: begin
                if (op == OP_CMP) begin
                    state_d = hit_any ? RES_HIT : RES_MISS;
                    maddr_d = hit_any ? hit_idx : '0;
                end
            end
            RES_HIT: begin
                if (op == OP_CMP) begin
                    state_d = hit_any ? RES_HIT : RES_MISS;
                    maddr_d = hit_any ? hit_idx : '0;
                end else if (drop_match) begin
                    state_d = RES_MISS;
                    maddr_d = '0;
                end
            end
            default: begin
                state_d = RES_IDLE;
                maddr_d = '0;
            end
        endcase
    end

    // Address register and read data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            areg_q <= '0;
            rd_q   <= '0;
        end else begin
            if (op == OP_LDAR) areg_q <= addr_i;
            if (do_read)       rd_q   <= old_word;
        end
    end

    // Outputs
    always_comb begin
        match_o      = (state_q == RES_HIT);
        match_addr_o = maddr_q;
        free_addr_o  = free_any ? free_idx : '0;
        full_o       = !free_any;
        rd_data_o    = rd_q;
    end
endmodule

// File: rtl/cam_part_array_chk.sv
module cam_part_array_chk
    import cam_pkg::*;
#(
    parameter int W  = 64,
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    op_i,
    input logic [1:0]    src_i,
    input logic [AW-1:0] addr_i,
    input logic [W-1:0]  rd_data_o,
    input logic          match_o,
    input logic [AW-1:0] match_addr_o,
    input logic [AW-1:0] free_addr_o,
    input logic          full_o
);
    // R11
    match_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != OP_CMP && op_i != OP_SETV) |=> ($stable(match_o) && $stable(match_addr_o)));

    // R8
    miss_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !match_o |-> (match_addr_o == '0));

    // R2
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != OP_READ) |=> $stable(rd_data_o));

    // R10
    full_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_WRITE && src_i == SRC_FREE && full_o) |=> (full_o && $stable(free_addr_o)));

    // R9
    fill_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_WRITE && src_i == SRC_ADDR && !full_o && addr_i == free_addr_o)
        |=> (full_o || free_addr_o != $past(free_addr_o)));

    // R9
    full_ptr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> (free_addr_o == '0));
endmodule

bind cam_part_array cam_part_array_chk #(.W(W), .AW(AW)) chk_i (.*);

// File: tb/cam_part_array_tb_top.sv
module cam_part_array_tb_top;
    import cam_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_i = '0;
    logic [1:0]  src_i = '0;
    logic [3:0]  addr_i = '0;
    logic [63:0] wdata_i = '0;
    logic [63:0] mask_i = '0;
    logic        wmask_en_i = 1'b0;
    logic [63:0] cmp_i = '0;
    logic [2:0]  part_i = '0;
    logic [63:0] rd_data_o;
    logic        match_o;
    logic [3:0]  match_addr_o;
    logic [3:0]  free_addr_o;
    logic        full_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cam_part_array dut_i (.*);

    typedef struct packed {
        logic [63:0] cmp;
        logic [63:0] mask;
        logic [2:0]  part;
        logic        flag;
        logic [3:0]  addr;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{64'h1111_2222_3333_4444, 64'h0, 3'b000, 1'b1, 4'd0},
        '{64'h1111_2222_3333_5555, 64'h0, 3'b000, 1'b1, 4'd1},
        '{64'hAAAA_2222_3333_4444, 64'h0, 3'b000, 1'b1, 4'd2},
        '{64'h0000_0000_0000_0000, 64'h0, 3'b000, 1'b0, 4'd0},
        '{64'h1111_2222_3333_5555, 64'h0000_0000_0000_FFFF, 3'b000, 1'b1, 4'd0},
        '{64'hFFFF_2222_3333_4444, 64'hFFFF_0000_0000_0000, 3'b000, 1'b1, 4'd0},
        '{64'h1111_2222_3333_9999, 64'h0, 3'b001, 1'b1, 4'd0},
        '{64'hBBBB_2222_3333_4444, 64'h0, 3'b101, 1'b1, 4'd0},
        '{64'hBBBB_2222_3333_5555, 64'h0, 3'b101, 1'b1, 4'd1},
        '{64'hAAAA_0000_0000_0000, 64'h0, 3'b011, 1'b1, 4'd2},
        '{64'h0000_0000_0000_5555, 64'h0, 3'b111, 1'b1, 4'd1},
        '{64'h1111_2222_3333_6666, 64'h0, 3'b000, 1'b0, 4'd0},
        '{64'h1111_2222_3333_6666, 64'h0, 3'b001, 1'b1, 4'd0},
        '{64'hFFFF_FFFF_FFFF_4444, 64'h0, 3'b111, 1'b1, 4'd0},
        '{64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF_FFFF_FFFF, 3'b000, 1'b1, 4'd0}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input cam_op_e op, input cam_src_e src, input logic [3:0] addr,
                          input logic [63:0] wd, input logic [63:0] msk, input logic men,
                          input logic [63:0] cmp, input logic [2:0] part);
        @(negedge clk);
        op_i = op; src_i = src; addr_i = addr; wdata_i = wd;
        mask_i = msk; wmask_en_i = men; cmp_i = cmp; part_i = part;
        @(posedge clk);
        #1;
        op_i = OP_NOP;
    endtask

    task automatic wr(input cam_src_e src, input logic [3:0] a, input logic [63:0] d);
        run_op(OP_WRITE, src, a, d, 64'h0, 1'b0, 64'h0, 3'b000);
    endtask

    task automatic rd(input cam_src_e src, input logic [3:0] a);
        run_op(OP_READ, src, a, 64'h0, 64'h0, 1'b0, 64'h0, 3'b000);
    endtask

    task automatic setv(input cam_src_e src, input logic [3:0] a, input logic [1:0] v);
        run_op(OP_SETV, src, a, {62'h0, v}, 64'h0, 1'b0, 64'h0, 3'b000);
    endtask

    task automatic cmpq(input logic [63:0] c, input logic [63:0] m, input logic [2:0] p);
        run_op(OP_CMP, SRC_ADDR, 4'd0, 64'h0, m, 1'b0, c, p);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 match", 64'(match_o), 64'd0);
        chk("R1 maddr", 64'(match_addr_o), 64'd0);
        chk("R1 free", 64'(free_addr_o), 64'd0);
        chk("R1 full", 64'(full_o), 64'd0);
        chk("R1 rd", rd_data_o, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 / R9 fill the first entries
        wr(SRC_ADDR, 4'd0, 64'h1111_2222_3333_4444);
        chk("R9 free after first write", 64'(free_addr_o), 64'd1);
        wr(SRC_ADDR, 4'd1, 64'h1111_2222_3333_5555);
        wr(SRC_ADDR, 4'd2, 64'hAAAA_2222_3333_4444);
        wr(SRC_ADDR, 4'd3, 64'h0000_0000_0000_0000);
        wr(SRC_ADDR, 4'd4, 64'h1111_2222_3333_4444);
        chk("R9 free after five writes", 64'(free_addr_o), 64'd5);
        setv(SRC_ADDR, 4'd3, VLD_SKIP);
        chk("R7 skip is not empty", 64'(free_addr_o), 64'd5);
        rd(SRC_ADDR, 4'd2);
        chk("R2 read explicit", rd_data_o, 64'hAAAA_2222_3333_4444);

        // R5 R6 R7 R8 compare table
        for (int k = 0; k < NV; k++) begin
            cmpq(VEC[k].cmp, VEC[k].mask, VEC[k].part);
            chk($sformatf("R5/R6/R8 vec%0d flag", k), 64'(match_o), 64'(VEC[k].flag));
            chk($sformatf("R5/R6/R8 vec%0d addr", k), 64'(match_addr_o), 64'(VEC[k].addr));
        end

        // R11 results hold across non-compare ops
        run_op(OP_NOP, SRC_ADDR, 4'd0, 64'h0, 64'h0, 1'b0, 64'h0, 3'b000);
        wr(SRC_ADDR, 4'd6, 64'h7777_0000_0000_0007);
        chk("R11 hold flag", 64'(match_o), 64'd1);
        chk("R11 hold addr", 64'(match_addr_o), 64'd0);
        chk("R9 free unchanged", 64'(free_addr_o), 64'd5);

        // R4 address sources
        run_op(OP_LDAR, SRC_ADDR, 4'd1, 64'h0, 64'h0, 1'b0, 64'h0, 3'b000);
        rd(SRC_AREG, 4'd9);
        chk("R4 address register", rd_data_o, 64'h1111_2222_3333_5555);
        cmpq(64'hAAAA_2222_3333_4444, 64'h0, 3'b000);
        rd(SRC_MATCH, 4'd9);
        chk("R4 match pointer read", rd_data_o, 64'hAAAA_2222_3333_4444);
        wr(SRC_FREE, 4'd9, 64'h0123_4567_89AB_CDEF);
        chk("R4 free pointer advance", 64'(free_addr_o), 64'd7);
        rd(SRC_ADDR, 4'd5);
        chk("R4 free pointer write", rd_data_o, 64'h0123_4567_89AB_CDEF);

        // R3 masked and unmasked writes
        run_op(OP_WRITE, SRC_ADDR, 4'd5, 64'hFFFF_FFFF_FFFF_FFFF,
               64'hFFFF_FFFF_0000_0000, 1'b1, 64'h0, 3'b000);
        rd(SRC_ADDR, 4'd5);
        chk("R3 masked write", rd_data_o, 64'h0123_4567_FFFF_FFFF);
        run_op(OP_WRITE, SRC_ADDR, 4'd6, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0,
               64'h0, 3'b000);
        rd(SRC_ADDR, 4'd6);
        chk("R3 mask disabled", rd_data_o, 64'h0);

        // R7 empty and random-access entries do not match
        setv(SRC_ADDR, 4'd0, VLD_EMPTY);
        chk("R7 empty frees entry", 64'(free_addr_o), 64'd0);
        setv(SRC_ADDR, 4'd1, VLD_RAND);
        cmpq(64'h1111_2222_3333_5555, 64'h0, 3'b000);
        chk("R7 random-access no match", 64'(match_o), 64'd0);
        chk("R8 miss addr", 64'(match_addr_o), 64'd0);

        // R10 match pointer unusable while missed
        rd(SRC_MATCH, 4'd0);
        chk("R10 read via missed match", rd_data_o, 64'h0);
        wr(SRC_MATCH, 4'd0, 64'h5);
        chk("R10 write via missed match", 64'(free_addr_o), 64'd0);

        // R8 priority skips empty entry; R11 invalidating matched entry
        cmpq(64'h1111_2222_3333_4444, 64'h0, 3'b000);
        chk("R8 priority past empty", 64'(match_addr_o), 64'd4);
        chk("R8 flag", 64'(match_o), 64'd1);
        setv(SRC_MATCH, 4'd0, VLD_SKIP);
        chk("R11 drop flag", 64'(match_o), 64'd0);
        chk("R11 drop addr", 64'(match_addr_o), 64'd0);

        // R9 fill until full
        for (int k = 0; k < 10; k++) begin
            wr(SRC_FREE, 4'd0, 64'h100 + 64'(k));
            chk($sformatf("R9 free step%0d", k), 64'(free_addr_o),
                (k == 0) ? 64'd7 : ((k == 9) ? 64'd0 : 64'(7 + k)));
            chk($sformatf("R9 full step%0d", k), 64'(full_o), (k == 9) ? 64'd1 : 64'd0);
        end

        // R10 free pointer unusable while full
        wr(SRC_FREE, 4'd0, 64'hDEAD);
        chk("R10 full stays", 64'(full_o), 64'd1);
        rd(SRC_ADDR, 4'd0);
        chk("R10 entry0 unchanged", rd_data_o, 64'h100);
        rd(SRC_ADDR, 4'd15);
        chk("R9 last entry", rd_data_o, 64'h109);
        rd(SRC_FREE, 4'd0);
        chk("R10 read via full free", rd_data_o, 64'h109);

        // R1 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #2;
        chk("R1 rerun match", 64'(match_o), 64'd0);
        chk("R1 rerun free", 64'(free_addr_o), 64'd0);
        chk("R1 rerun full", 64'(full_o), 64'd0);
        chk("R1 rerun rd", rd_data_o, 64'd0);

        finish_run();
    end
endmodule